// File: doc/BRIEF.md
# General-Purpose I/O Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose pins behind a simple register bus. Each register word has one bit per pin. It holds the value driven on each pin and whether each pin is driven at all. It also holds the sampled pin inputs, after a two-flop synchroniser, as a read-only word.

Each pin can be picked as an interrupt source. For each source, software chooses edge or level triggering and which polarity counts. A detected event sets a sticky per-pin status bit. The status word is masked by a per-pin enable word and ORed into one interrupt line for the whole bank.

Every writable register has three write addresses: a plain one, one that sets bits and one that clears bits. Status bits can only be removed through the clear address, so software can acknowledge one pin without disturbing the others.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, and `pinOut`, `pinOe` and `irqOut` are 0.
- R2: The register index is `busAddr[6:4]` and the alias is `busAddr[3:2]`. Alias 0 writes the value, alias 1 ORs the data in and alias 2 removes the set data bits. A write with alias 3 has no effect. Reads return the register at any alias. Indices: 0 out data, 1 input, 2 out enable, 3 source select, 4 irq enable, 5 level select, 6 polarity, 7 status.
- R3: Index 1 returns the pin inputs two clock edges after they change. Writes to index 1 have no effect.
- R4: `pinOut` always equals out data, and `pinOe` always equals out enable.
- R5: With level select 0 and polarity 1, a 0-to-1 change of a synchronised input sets that pin's status bit on the following edge.
- R6: With level select 0 and polarity 0, a 1-to-0 change sets the status bit, and a 0-to-1 change does not.
- R7: With level select 1, the status bit is set on every cycle in which the synchronised input equals the polarity bit. Once the input leaves that level, a clear removes the bit.
- R8: A pin whose source-select bit is 0 never sets its status bit.
- R9: Status bits are removed only by the clear alias of index 7. Plain and set writes to index 7 have no effect.
- R10: When a detection and a clear of the same status bit happen in the same cycle, the bit stays set.
- R11: `irqOut` is 1 exactly when some bit is set in both status and irq enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 7 | Byte address (index in bits 6:4, alias in bits 3:2) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| pinIn | input | 32 | Asynchronous pin inputs |
| pinOut | output | 32 | Value driven on each pin |
| pinOe | output | 32 | Drive enable per pin (0 means the pin is an input) |
| irqOut | output | 1 | Bank interrupt |

## Verification
The hardest case to reach from the ports is a clear arriving in the same cycle as a detection, because detection lags the pin input by the synchroniser stages. The stimulus reaches it by holding a level-triggered pin at its active level and then issuing the clear, which makes the two coincide on every cycle. Edge cases depend on when the input changes relative to the synchroniser. The bench drives pin changes on the falling edge and waits a fixed number of edges before reading status. A behavioural model that is updated on every rising edge is compared against all outputs throughout.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NUM_REGS = 8;
  localparam int IDX_W = $clog2(NUM_REGS);

  localparam int IDX_OUT = 0;
  localparam int IDX_IN  = 1;
  localparam int IDX_OE  = 2;
  localparam int IDX_SEL = 3;
  localparam int IDX_EN  = 4;
  localparam int IDX_LVL = 5;
  localparam int IDX_POL = 6;
  localparam int IDX_STS = 7;

  typedef enum logic [1:0] {
    ALIAS_PLAIN = 2'd0,
    ALIAS_SET   = 2'd1,
    ALIAS_CLR   = 2'd2,
    ALIAS_NONE  = 2'd3
  } aliasKind_t;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrHit;
    aliasKind_t          kind;
    logic [IDX_W-1:0]    rdIdx;
  } busStrobe_t;
endpackage

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  localparam int IDX_LO = 4;

  logic [IDX_W-1:0] regIdx;
  aliasKind_t       kind;

  assign regIdx = busAddr[IDX_LO +: IDX_W];
  assign kind   = aliasKind_t'(busAddr[3:2]);

  always_comb begin
    strobe.wrHit = '0;
    strobe.kind  = kind;
    strobe.rdIdx = regIdx;
    if (busValid && busWrite && kind != ALIAS_NONE) begin
      strobe.wrHit[regIdx] = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  input  logic levelMode,
  input  logic activeHigh,
  input  logic srcSel,
  output logic syncVal,
  output logic hit
);
  logic meta;
  logic syncQ;
  logic prevQ;
  logic edgeHit;
  logic levelHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta  <= 1'b0;
      syncQ <= 1'b0;
      prevQ <= 1'b0;
    end else begin
      meta  <= pinRaw;
      syncQ <= meta;
      prevQ <= syncQ;
    end
  end

  assign edgeHit  = activeHigh ? (syncQ & ~prevQ) : (~syncQ & prevQ);
  assign levelHit = activeHigh ? syncQ : ~syncQ;
  assign hit      = srcSel & (levelMode ? levelHit : edgeHit);
  assign syncVal  = syncQ;
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  busStrobe_t      strobe,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] pinIn,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] outQ,
  output logic [PINS-1:0] oeQ,
  output logic [PINS-1:0] statusQ,
  output logic [PINS-1:0] enableQ
);
  logic [PINS-1:0] selQ;
  logic [PINS-1:0] lvlQ;
  logic [PINS-1:0] polQ;
  logic [PINS-1:0] syncIn;
  logic [PINS-1:0] detHit;
  logic [PINS-1:0] stsClr;

  function automatic logic [PINS-1:0] applyAlias(
    input logic [PINS-1:0] cur,
    input logic [PINS-1:0] dat,
    input aliasKind_t      k
  );
    case (k)
      ALIAS_PLAIN: applyAlias = dat;
      ALIAS_SET:   applyAlias = cur | dat;
      ALIAS_CLR:   applyAlias = cur & ~dat;
      default:     applyAlias = cur;
    endcase
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < PINS; gi++) begin : g_pin
      gpio_pin_detect u_det (
        .clk       (clk),
        .rstN      (rstN),
        .pinRaw    (pinIn[gi]),
        .levelMode (lvlQ[gi]),
        .activeHigh(polQ[gi]),
        .srcSel    (selQ[gi]),
        .syncVal   (syncIn[gi]),
        .hit       (detHit[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ    <= '0;
      oeQ     <= '0;
      selQ    <= '0;
      enableQ <= '0;
      lvlQ    <= '0;
      polQ    <= '0;
    end else begin
      if (strobe.wrHit[IDX_OUT]) outQ    <= applyAlias(outQ, wdata, strobe.kind);
      if (strobe.wrHit[IDX_OE])  oeQ     <= applyAlias(oeQ, wdata, strobe.kind);
      if (strobe.wrHit[IDX_SEL]) selQ    <= applyAlias(selQ, wdata, strobe.kind);
      if (strobe.wrHit[IDX_EN])  enableQ <= applyAlias(enableQ, wdata, strobe.kind);
      if (strobe.wrHit[IDX_LVL]) lvlQ    <= applyAlias(lvlQ, wdata, strobe.kind);
      if (strobe.wrHit[IDX_POL]) polQ    <= applyAlias(polQ, wdata, strobe.kind);
    end
  end

  assign stsClr = (strobe.wrHit[IDX_STS] && strobe.kind == ALIAS_CLR) ? wdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= (statusQ & ~stsClr) | detHit;
    end
  end

  always_comb begin
    case (strobe.rdIdx)
      IDX_W'(IDX_OUT): rdata = outQ;
      IDX_W'(IDX_IN):  rdata = syncIn;
      IDX_W'(IDX_OE):  rdata = oeQ;
      IDX_W'(IDX_SEL): rdata = selQ;
      IDX_W'(IDX_EN):  rdata = enableQ;
      IDX_W'(IDX_LVL): rdata = lvlQ;
      IDX_W'(IDX_POL): rdata = polQ;
      default:         rdata = statusQ;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PINS-1:0]   busWdata,
  output logic [PINS-1:0]   busRdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              irqOut
);
  busStrobe_t      strobe;
  logic [PINS-1:0] statusQ;
  logic [PINS-1:0] enableQ;

  gpio_bus_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpio_bank_datapath #(.PINS(PINS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wdata  (busWdata),
    .pinIn  (pinIn),
    .rdata  (busRdata),
    .outQ   (pinOut),
    .oeQ    (pinOe),
    .statusQ(statusQ),
    .enableQ(enableQ)
  );

  assign irqOut = |(statusQ & enableQ);
endmodule

// File: rtl/gpio_irq_bank_checker.sv
module gpio_irq_bank_checker #(
  parameter int PINS   = 32,
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [PINS-1:0]   busWdata,
  input logic [PINS-1:0]   pinOut,
  input logic [PINS-1:0]   pinOe,
  input logic              irqOut,
  input logic [PINS-1:0]   statusQ,
  input logic [PINS-1:0]   enableQ
);
  logic wrStsClr;
  logic wrOutPlain;
  logic wrOeSet;

  assign wrStsClr   = busValid && busWrite && busAddr == ADDR_W'(7'h78);
  assign wrOutPlain = busValid && busWrite && busAddr == ADDR_W'(7'h00);
  assign wrOeSet    = busValid && busWrite && busAddr == ADDR_W'(7'h24);

  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (enableQ != '0));

  assert_status_drop_only_by_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusQ) & ~statusQ) & ~($past(wrStsClr) ? $past(busWdata) : '0)) == '0);

  assert_plain_write_drives_pins_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrOutPlain |=> (pinOut == $past(busWdata)));

  assert_set_alias_ors_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrOeSet |=> ((pinOe & $past(busWdata)) == $past(busWdata)));
endmodule

bind gpio_irq_bank gpio_irq_bank_checker #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  // behavioural model
  logic [31:0] mReg [8];
  logic [31:0] inHist [$];
  logic [31:0] mSyncNow;
  logic [31:0] mSyncPrev;

  initial begin
    for (int i = 0; i < 8; i++) mReg[i] = '0;
    inHist = {32'h0, 32'h0, 32'h0};
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [2:0] idx);
    return (idx == 3'd1) ? inHist[1] : mReg[idx];
  endfunction

  always @(posedge clk) begin
    logic [31:0] det;
    logic [31:0] rise;
    logic [31:0] fall;
    logic [31:0] lvlAct;
    logic [2:0]  idx;
    logic [1:0]  al;
    if (!rstN) begin
      for (int i = 0; i < 8; i++) mReg[i] = '0;
      inHist = {32'h0, 32'h0, 32'h0};
    end else begin
      mSyncNow  = inHist[1];
      mSyncPrev = inHist[2];
      rise   = mSyncNow & ~mSyncPrev;
      fall   = ~mSyncNow & mSyncPrev;
      lvlAct = (mSyncNow & mReg[6]) | (~mSyncNow & ~mReg[6]);
      det = mReg[3] & ((mReg[5] & lvlAct) | (~mReg[5] & ((mReg[6] & rise) | (~mReg[6] & fall))));
      idx = busAddr[6:4];
      al  = busAddr[3:2];
      if (busValid && busWrite && idx != 3'd1 && idx != 3'd7) begin
        if (al == 2'd0) mReg[idx] = busWdata;
        else if (al == 2'd1) mReg[idx] = mReg[idx] | busWdata;
        else if (al == 2'd2) mReg[idx] = mReg[idx] & ~busWdata;
      end
      if (busValid && busWrite && idx == 3'd7 && al == 2'd2) mReg[7] = mReg[7] & ~busWdata;
      mReg[7] = mReg[7] | det;
      inHist.pop_back();
      inHist.push_front(pinIn);
    end
    #1;
    if (!finished) begin
      check(pinOut == mReg[0], "R4 model pinOut", pinOut, mReg[0]);
      check(pinOe == mReg[2], "R4 model pinOe", pinOe, mReg[2]);
      check(irqOut == (|(mReg[7] & mReg[4])), "R11 model irq", 32'(irqOut), 32'(|(mReg[7] & mReg[4])));
      check(busRdata == modelRead(busAddr[6:4]), "R2 model read", busRdata, modelRead(busAddr[6:4]));
    end
  end

  task automatic busWr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic readCheck(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    check(busRdata === exp, tag, busRdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) readCheck(7'(i * 16), 32'h0, "R1 reset register");
    check(pinOut == 0 && pinOe == 0 && !irqOut, "R1 reset pins", pinOut | pinOe, 32'h0);

    // R2 alias behaviour on out data, R4 pins
    busWr(7'h00, 32'hA5A5_A5A5);
    busWr(7'h04, 32'h0000_FFFF);
    readCheck(7'h08, 32'hA5A5_FFFF, "R2 set alias");
    busWr(7'h08, 32'hF000_0000);
    readCheck(7'h00, 32'h05A5_FFFF, "R2 clear alias");
    busWr(7'h0C, 32'hFFFF_FFFF);
    readCheck(7'h00, 32'h05A5_FFFF, "R2 alias 3 ignored");
    check(pinOut == 32'h05A5_FFFF, "R4 pinOut", pinOut, 32'h05A5_FFFF);
    busWr(7'h24, 32'h0000_00F0);
    check(pinOe == 32'h0000_00F0, "R4 pinOe", pinOe, 32'h0000_00F0);

    // R3 input sync and read-only
    @(negedge clk); pinIn = 32'h8000_0001;
    busWr(7'h10, 32'h0);
    idle(2);
    readCheck(7'h10, 32'h8000_0001, "R3 input read");
    @(negedge clk); pinIn = 32'h0;
    idle(3);

    // interrupt configuration: all pins selected, pin3 rising
    busWr(7'h30, 32'hFFFF_FFFF);
    busWr(7'h78, 32'hFFFF_FFFF);
    busWr(7'h64, 32'h0000_0008);
    busWr(7'h44, 32'h0000_0008);
    @(negedge clk); pinIn[3] = 1'b1;
    idle(4);
    readCheck(7'h70, 32'h0000_0008, "R5 rising edge");
    check(irqOut == 1'b1, "R11 irq asserted", 32'(irqOut), 32'h1);
    busWr(7'h70, 32'h0);
    busWr(7'h74, 32'h0);
    readCheck(7'h70, 32'h0000_0008, "R9 plain/set ignored");
    busWr(7'h78, 32'h0000_0008);
    readCheck(7'h70, 32'h0, "R9 clear alias");
    check(irqOut == 1'b0, "R11 irq released", 32'(irqOut), 32'h0);

    // R6 falling on pin5 (polarity 0)
    @(negedge clk); pinIn[5] = 1'b1;
    idle(4);
    readCheck(7'h70, 32'h0, "R6 rise ignored in falling mode");
    @(negedge clk); pinIn[5] = 1'b0;
    idle(4);
    readCheck(7'h70, 32'h0000_0020, "R6 falling edge");
    check(irqOut == 1'b0, "R11 masked by enable", 32'(irqOut), 32'h0);
    busWr(7'h78, 32'h0000_0020);

    // R7 / R10 level high on pin7
    busWr(7'h54, 32'h0000_0080);
    busWr(7'h64, 32'h0000_0080);
    @(negedge clk); pinIn[7] = 1'b1;
    idle(4);
    readCheck(7'h70, 32'h0000_0080, "R7 level set");
    busWr(7'h78, 32'h0000_0080);
    readCheck(7'h70, 32'h0000_0080, "R10 detection beats clear");
    @(negedge clk); pinIn[7] = 1'b0;
    idle(4);
    busWr(7'h78, 32'h0000_0080);
    readCheck(7'h70, 32'h0, "R7 level released then cleared");

    // R8 unselected pin9 rising
    busWr(7'h38, 32'h0000_0200);
    busWr(7'h64, 32'h0000_0200);
    @(negedge clk); pinIn[9] = 1'b1;
    idle(4);
    readCheck(7'h70, 32'h0, "R8 unselected pin");

    idle(2);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule